// File: doc/BRIEF.md
# Arrival-Order Snooping Bus Arbiter

This block owns the single shared bus that the private data caches of a small multiprocessor use to keep coherent. Each cache controller raises a one-cycle request carrying a bus command and a block address. Requests are queued by the order in which they arrived, and the bus is handed out strictly in that order. Requests that arrive in the same cycle are ordered by ascending requester index. While a transaction owns the bus, its command and address are broadcast to every other cache. The combined shared and dirty snoop lines from those caches are gathered and handed back to the requester when the transaction completes.

Main memory sits directly behind the bus. A block fill holds the bus for a fixed number of cycles, set by `FILL_LAT` (default 10). An upgrade carries no data and completes in a single bus cycle. A dirty-block writeback is absorbed by a write buffer: it never takes the bus and is acknowledged on the next cycle. Each requester may have only one transaction outstanding, so the queue of requester IDs is exactly as deep as the number of requesters.

Top module: `snoop_bus_arb`

## Requirements
- R1: At most one bit of `gnt_o` is set in any cycle, and the owner does not change before its transaction completes.
- R2: Transactions from requests accepted in different cycles are granted in the order those requests were accepted.
- R3: Requests accepted in the same cycle are granted in ascending requester index.
- R4: A read (cmd 0) or read-for-ownership (cmd 1) holds the grant for exactly `FILL_LAT` cycles. `done_o` for the owner is high in the last of those cycles.
- R5: An upgrade (cmd 2) holds the grant for exactly one cycle, with `done_o` high in that cycle.
- R6: A writeback (cmd 3) never produces a grant. It raises the requester's `done_o` in the cycle after the request was sampled, even while another transaction holds the bus.
- R7: While the bus is owned, `snp_valid_o` is 1 and `snp_cmd_o`/`snp_addr_o` carry the owner's captured command and address. `snp_tgt_o` is the complement of the owner's grant bit. When the bus is idle, `snp_valid_o` is 0.
- R8: In the completing cycle, `resp_shared_o`/`resp_dirty_o` are the OR of the non-owner `snp_shared_i`/`snp_dirty_i` bits over every cycle of the tenure. The owner's own bits are ignored.
- R9: A request (any command) from a requester whose bus transaction is still queued or in progress is ignored. It produces no second tenure, no writeback acknowledge and no change of the snooped address.
- R10: During reset, `gnt_o`, `done_o` and `snp_valid_o` are all zero.
- R11: The first grant comes one cycle after the request is sampled. A queued requester is granted in the cycle right after the previous owner's completing cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NREQ | One-cycle request strobe per requester |
| cmd_i | input | 2*NREQ | Per-requester command, 2 bits each (0 read, 1 read-own, 2 upgrade, 3 writeback) |
| addr_i | input | NREQ*ADDR_W | Per-requester block address |
| gnt_o | output | NREQ | One-hot bus ownership |
| done_o | output | NREQ | Completion strobe per requester |
| resp_shared_o | output | 1 | Combined shared response, valid with done |
| resp_dirty_o | output | 1 | Combined dirty response, valid with done |
| snp_valid_o | output | 1 | Snoop broadcast valid |
| snp_cmd_o | output | 2 | Broadcast command |
| snp_addr_o | output | ADDR_W | Broadcast address |
| snp_tgt_o | output | NREQ | Caches that must snoop this cycle |
| snp_shared_i | input | NREQ | Shared response from each snooper |
| snp_dirty_i | input | NREQ | Dirty response from each snooper |

## Verification
The bench builds the block with four requesters, 16-bit addresses and a fill latency of 5 cycles. The short fills keep each tenure brief, which makes it affordable to sweep every one of the 15 non-empty same-cycle request sets, each with its own mix of reads, read-owns and upgrades. Expected grant order, start cycles and tenure lengths are computed arithmetically from the requester index and the command. Staggered arrivals, writebacks issued under a busy bus, repeated requests from a pending requester and snoop responses pulsed mid-tenure are then driven at fixed cycles.

// File: rtl/snb_pkg.sv
package snb_pkg;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;

  // Commands that must wait for a memory block fill.
  function automatic logic cmd_fills(input bus_cmd_e c);
    return (c == BC_RD) || (c == BC_RDX);
  endfunction

  // Number of cycles a command keeps the bus.
  function automatic int unsigned tenure_len(input bus_cmd_e c, input int unsigned fill_lat);
    return cmd_fills(c) ? fill_lat : 32'd1;
  endfunction

  // Modular pointer advance for a ring of arbitrary depth.
  function automatic int unsigned ring_add(input int unsigned p, input int unsigned k,
                                           input int unsigned depth);
    int unsigned s;
    s = p + k;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/snb_id_fifo.sv
module snb_id_fifo
  import snb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [DEPTH-1:0]                      push_i,
  input  logic                                  pop_i,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] head_o,
  output logic                                  empty_o
);
  localparam int unsigned IDW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW  = $clog2(DEPTH + 1);

  logic [IDW-1:0] slot_q  [DEPTH];
  logic [IDW-1:0] slot_of [DEPTH];
  logic [IDW-1:0] rd_q, wr_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  n_push;

  // Same-cycle pushes land in ascending requester order.
  always_comb begin
    int unsigned off;
    off = 0;
    for (int i = 0; i < DEPTH; i++) begin
      slot_of[i] = IDW'(ring_add(wr_q, off, DEPTH));
      if (push_i[i]) off++;
    end
    n_push = CW'(off);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (push_i[i]) slot_q[slot_of[i]] <= IDW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= IDW'(ring_add(wr_q, n_push, DEPTH));
      if (pop_i) rd_q <= IDW'(ring_add(rd_q, 1, DEPTH));
      cnt_q <= cnt_q + n_push - CW'(pop_i);
    end
  end

  assign head_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);

  // R2: the queue is popped only when it holds an entry
  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

  // R9: one entry per requester keeps the ring from overflowing
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) + 32'(n_push)) <= (DEPTH + 32'(pop_i)));

endmodule

// File: rtl/snb_bus_fsm.sv
module snb_bus_fsm
  import snb_pkg::*;
#(
  parameter int unsigned NREQ     = 4,
  parameter int unsigned FILL_LAT = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 q_empty_i,
  input  logic [((NREQ > 1) ? $clog2(NREQ) : 1)-1:0] q_head_i,
  input  bus_cmd_e                             head_cmd_i,
  output logic                                 grant_o,
  output logic                                 busy_o,
  output logic [((NREQ > 1) ? $clog2(NREQ) : 1)-1:0] owner_o,
  output logic                                 last_o
);
  localparam int unsigned IDW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int unsigned LW  = (FILL_LAT > 1) ? $clog2(FILL_LAT + 1) : 1;

  logic           busy_q;
  logic [IDW-1:0] owner_q;
  logic [LW-1:0]  left_q;

  assign last_o  = busy_q && (left_q == '0);
  assign grant_o = (!busy_q || last_o) && !q_empty_i;
  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      left_q  <= '0;
    end else if (grant_o) begin
      busy_q  <= 1'b1;
      owner_q <= q_head_i;
      left_q  <= LW'(tenure_len(head_cmd_i, FILL_LAT) - 1);
    end else if (last_o) begin
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      left_q  <= left_q - 1'b1;
    end
  end

  // R1: ownership is held until the completing cycle
  a_r1_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && $stable(owner_q)));

  // R11: a waiting request takes the bus right after completion
  a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !q_empty_i) |=> busy_q);

endmodule

// File: rtl/snb_snoop_collect.sv
module snb_snoop_collect #(
  parameter int unsigned NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            busy_i,
  input  logic [NREQ-1:0] owner_oh_i,
  input  logic [NREQ-1:0] shared_i,
  input  logic [NREQ-1:0] dirty_i,
  output logic [NREQ-1:0] tgt_o,
  output logic            shared_o,
  output logic            dirty_o
);
  logic acc_sh_q, acc_dt_q;
  logic cur_sh, cur_dt;

  assign tgt_o  = busy_i ? ~owner_oh_i : '0;
  assign cur_sh = |(shared_i & tgt_o);
  assign cur_dt = |(dirty_i & tgt_o);
  assign shared_o = acc_sh_q | cur_sh;
  assign dirty_o  = acc_dt_q | cur_dt;

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      acc_sh_q <= 1'b0;
      acc_dt_q <= 1'b0;
    end else if (busy_i) begin
      acc_sh_q <= shared_o;
      acc_dt_q <= dirty_o;
    end
  end

  // R8: a shared report stays visible for the rest of the tenure
  a_r8_sticky_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && shared_o && !start_i) |=> (!busy_i || shared_o));

  // R8: a dirty report stays visible for the rest of the tenure
  a_r8_sticky_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && dirty_o && !start_i) |=> (!busy_i || dirty_o));

endmodule

// File: rtl/snoop_bus_arb.sv
module snoop_bus_arb
  import snb_pkg::*;
#(
  parameter int unsigned NREQ     = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned FILL_LAT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_i,
  input  logic [2*NREQ-1:0]        cmd_i,
  input  logic [NREQ*ADDR_W-1:0]   addr_i,
  output logic [NREQ-1:0]          gnt_o,
  output logic [NREQ-1:0]          done_o,
  output logic                     resp_shared_o,
  output logic                     resp_dirty_o,
  output logic                     snp_valid_o,
  output logic [1:0]               snp_cmd_o,
  output logic [ADDR_W-1:0]        snp_addr_o,
  output logic [NREQ-1:0]          snp_tgt_o,
  input  logic [NREQ-1:0]          snp_shared_i,
  input  logic [NREQ-1:0]          snp_dirty_i
);
  localparam int unsigned IDW = (NREQ > 1) ? $clog2(NREQ) : 1;

  bus_cmd_e        req_cmd [NREQ];
  bus_cmd_e        cmd_q   [NREQ];
  logic [ADDR_W-1:0] addr_q [NREQ];
  logic [NREQ-1:0] accept, enq, wb_hit;
  logic [NREQ-1:0] pending_q, wb_ack_q;
  logic [NREQ-1:0] owner_oh, bus_done;

  logic           q_empty, q_pop;
  logic [IDW-1:0] q_head, owner;
  logic           busy, last;
  bus_cmd_e       head_cmd;

  // Request decode: pending requesters are ignored, writebacks bypass the bus.
  for (genvar g = 0; g < NREQ; g++) begin : g_req
    assign req_cmd[g] = bus_cmd_e'(cmd_i[2*g +: 2]);
    assign accept[g]  = req_i[g] && !pending_q[g];
    assign enq[g]     = accept[g] && (req_cmd[g] != BC_WB);
    assign wb_hit[g]  = accept[g] && (req_cmd[g] == BC_WB);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREQ; i++)
      if (enq[i]) begin
        cmd_q[i]  <= req_cmd[i];
        addr_q[i] <= addr_i[ADDR_W*i +: ADDR_W];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      wb_ack_q  <= '0;
    end else begin
      pending_q <= (pending_q | enq) & ~bus_done;
      wb_ack_q  <= wb_hit;
    end
  end

  snb_id_fifo #(.DEPTH(NREQ)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (enq),
    .pop_i   (q_pop),
    .head_o  (q_head),
    .empty_o (q_empty)
  );

  assign head_cmd = cmd_q[q_head];

  snb_bus_fsm #(.NREQ(NREQ), .FILL_LAT(FILL_LAT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_empty_i  (q_empty),
    .q_head_i   (q_head),
    .head_cmd_i (head_cmd),
    .grant_o    (q_pop),
    .busy_o     (busy),
    .owner_o    (owner),
    .last_o     (last)
  );

  assign owner_oh = busy ? (NREQ'(1) << owner) : '0;
  assign bus_done = last ? owner_oh : '0;

  snb_snoop_collect #(.NREQ(NREQ)) u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (q_pop),
    .busy_i     (busy),
    .owner_oh_i (owner_oh),
    .shared_i   (snp_shared_i),
    .dirty_i    (snp_dirty_i),
    .tgt_o      (snp_tgt_o),
    .shared_o   (resp_shared_o),
    .dirty_o    (resp_dirty_o)
  );

  assign gnt_o       = owner_oh;
  assign done_o      = bus_done | wb_ack_q;
  assign snp_valid_o = busy;
  assign snp_cmd_o   = busy ? cmd_q[owner] : BC_RD;
  assign snp_addr_o  = busy ? addr_q[owner] : '0;

  // R1: never more than one owner
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R7: snoop targets are exactly the non-owners
  a_r7_targets: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid_o |-> (((snp_tgt_o & gnt_o) == '0) && ((snp_tgt_o | gnt_o) == '1)));

  // R6: a writeback acknowledge never coincides with owning the bus
  a_r6_wb_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_ack_q) |-> ((wb_ack_q & gnt_o) == '0));

  // R9: bus completion goes only to a requester with a live entry
  a_r9_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_done) |-> ((bus_done & ~pending_q) == '0));

  // R2: the queue head always belongs to a pending requester
  a_r2_head_pending: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> pending_q[q_head]);

endmodule

// File: tb/snoop_bus_arb_tb.sv
module snoop_bus_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int FL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [2*N-1:0]  cmd = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N-1:0]    gnt, done, tgt;
  logic            rsh, rdt, svalid;
  logic [1:0]      scmd;
  logic [AW-1:0]   saddr;
  logic [N-1:0]    sh_in = '0, dt_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_bus_arb #(.NREQ(N), .ADDR_W(AW), .FILL_LAT(FL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cmd_i(cmd), .addr_i(addr),
    .gnt_o(gnt), .done_o(done), .resp_shared_o(rsh), .resp_dirty_o(rdt),
    .snp_valid_o(svalid), .snp_cmd_o(scmd), .snp_addr_o(saddr), .snp_tgt_o(tgt),
    .snp_shared_i(sh_in), .snp_dirty_i(dt_in)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [1:0]    exp_cmd  [N];
  logic [AW-1:0] exp_addr [N];

  int   t_own[64], t_st[64], t_len[64];
  logic t_sh[64], t_dt[64];
  int   n_t = 0;
  int   wb_id[16], wb_cy[16];
  int   n_wb = 0;
  int   snp_err = 0, g_err = 0;
  logic closed = 1'b1;
  logic [N-1:0] prev_g = '0;

  function automatic int oh2id(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int span(input logic [1:0] c);
    return (c <= 2'd1) ? FL : 1;
  endfunction

  // Monitor: logs tenures and writeback acknowledges, checks the broadcast.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_g = '0;
      closed = 1'b1;
    end else begin
      if (!$onehot0(gnt)) g_err++;
      if (gnt != '0) begin
        if ((gnt != prev_g) || closed) begin
          if (n_t < 64) begin
            t_own[n_t] = oh2id(gnt); t_st[n_t] = cyc; t_len[n_t] = 0;
            t_sh[n_t] = 1'b0; t_dt[n_t] = 1'b0;
          end
          n_t++;
        end
        if (n_t <= 64) t_len[n_t-1]++;
        closed = |(done & gnt);
        if (closed && n_t <= 64) begin t_sh[n_t-1] = rsh; t_dt[n_t-1] = rdt; end
        if (!svalid || tgt != ~gnt || scmd != exp_cmd[oh2id(gnt)] ||
            saddr != exp_addr[oh2id(gnt)]) snp_err++;
      end else begin
        closed = 1'b1;
        if (svalid) snp_err++;
      end
      for (int i = 0; i < N; i++)
        if (done[i] && !gnt[i] && n_wb < 16) begin
          wb_id[n_wb] = i; wb_cy[n_wb] = cyc; n_wb++;
        end
      prev_g = gnt;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic inject(input logic [N-1:0] m, input logic [2*N-1:0] c, output int t0);
    @(negedge clk);
    t0 = cyc;
    req = m;
    cmd = c;
    @(negedge clk);
    req = '0;
  endtask

  task automatic set_addr(input int i, input logic [AW-1:0] a, input logic upd);
    addr[AW*i +: AW] = a;
    if (upd) exp_addr[i] = a;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin exp_cmd[i] = 2'd0; exp_addr[i] = '0; end
    repeat (3) @(negedge clk);
    chk(gnt == '0, "R10 gnt in reset", int'(gnt), 0);
    chk(done == '0, "R10 done in reset", int'(done), 0);
    chk(svalid == 1'b0, "R10 snoop valid in reset", int'(svalid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(gnt == '0 && svalid == 1'b0, "R10 idle after reset", int'(gnt), 0);

    // Sweep of every same-cycle request set with mixed commands (R3 R4 R5 R11)
    for (int m = 1; m < (1 << N); m++) begin
      logic [2*N-1:0] cv;
      int t0, pos, k, tot, cnt;
      tot = 0; cnt = 0;
      for (int i = 0; i < N; i++) begin
        cv[2*i +: 2] = 2'((m + i) % 3);
        exp_cmd[i] = cv[2*i +: 2];
        set_addr(i, AW'(16'h0100 * m + i), 1'b1);
        if (m[i]) begin tot += span(cv[2*i +: 2]); cnt++; end
      end
      n_t = 0; n_wb = 0;
      inject(N'(m), cv, t0);
      repeat (tot + 3) @(negedge clk);
      chk(n_t == cnt, "R3 tenure count", n_t, cnt);
      pos = t0 + 2; k = 0;
      for (int i = 0; i < N; i++) if (m[i] && k < n_t) begin
        chk(t_own[k] == i, "R3 tie order", t_own[k], i);
        chk(t_st[k] == pos, "R11 grant start", t_st[k], pos);
        if (span(cv[2*i +: 2]) == FL)
          chk(t_len[k] == FL, "R4 fill tenure length", t_len[k], FL);
        else
          chk(t_len[k] == 1, "R5 upgrade tenure length", t_len[k], 1);
        pos += span(cv[2*i +: 2]); k++;
      end
    end

    // Staggered arrivals: 3, then 2, then 0 and 1 together (R2)
    begin
      int t0;
      for (int i = 0; i < N; i++) begin exp_cmd[i] = 2'd0; set_addr(i, AW'(16'h7000 + i), 1'b1); end
      n_t = 0;
      @(negedge clk); t0 = cyc; req = 4'b1000; cmd = '0;
      @(negedge clk); req = 4'b0100;
      @(negedge clk); req = 4'b0011;
      @(negedge clk); req = '0;
      repeat (4 * FL + 3) @(negedge clk);
      chk(n_t == 4, "R2 tenure count", n_t, 4);
      chk(t_own[0] == 3, "R2 first arrival", t_own[0], 3);
      chk(t_own[1] == 2, "R2 second arrival", t_own[1], 2);
      chk(t_own[2] == 0, "R2 third arrival low index", t_own[2], 0);
      chk(t_own[3] == 1, "R2 third arrival high index", t_own[3], 1);
      chk(t_st[3] == t0 + 2 + 3 * FL, "R11 back-to-back start", t_st[3], t0 + 2 + 3 * FL);
    end

    // Writebacks while the bus is busy (R6)
    begin
      int t0, t1;
      n_t = 0; n_wb = 0;
      exp_cmd[0] = 2'd0;
      inject(4'b0001, 8'b0000_0000, t0);
      inject(4'b0110, 8'b0011_1100, t1);
      repeat (FL + 3) @(negedge clk);
      chk(n_wb == 2, "R6 writeback acks", n_wb, 2);
      chk(wb_id[0] == 1 && wb_id[1] == 2, "R6 writeback ids", wb_id[0], 1);
      chk(wb_cy[0] == t1 + 1 && wb_cy[1] == t1 + 1, "R6 writeback ack cycle", wb_cy[0], t1 + 1);
      chk(n_t == 1 && t_own[0] == 0, "R6 writeback never owns bus", n_t, 1);
    end

    // Requests from a pending requester are ignored (R9)
    begin
      int t0, tx;
      n_t = 0; n_wb = 0;
      exp_cmd[1] = 2'd0;
      set_addr(1, 16'hBEE0, 1'b1);
      inject(4'b0010, 8'b0000_0000, t0);
      set_addr(1, 16'hCAF0, 1'b0);
      inject(4'b0010, 8'b0000_0000, tx);
      inject(4'b0010, 8'b0000_1100, tx);
      repeat (FL + 3) @(negedge clk);
      chk(n_t == 1, "R9 no second tenure", n_t, 1);
      chk(n_wb == 0, "R9 no writeback ack", n_wb, 0);
      chk(snp_err == 0, "R9 snooped address kept", snp_err, 0);
      n_t = 0;
      exp_addr[1] = 16'hCAF0;
      inject(4'b0010, 8'b0000_0000, t0);
      repeat (FL + 3) @(negedge clk);
      chk(n_t == 1 && t_st[0] == t0 + 2, "R9 accepted once free", t_st[0], t0 + 2);
    end

    // Snoop responses (R8)
    begin
      int t0;
      n_t = 0;
      exp_cmd[1] = 2'd1;
      sh_in = 4'b0010; dt_in = 4'b0010;
      inject(4'b0010, 8'b0000_0100, t0);
      repeat (FL + 3) @(negedge clk);
      chk(t_sh[0] == 1'b0, "R8 owner shared ignored", int'(t_sh[0]), 0);
      chk(t_dt[0] == 1'b0, "R8 owner dirty ignored", int'(t_dt[0]), 0);
      n_t = 0;
      exp_cmd[0] = 2'd0;
      sh_in = '0; dt_in = 4'b1001;
      inject(4'b0001, 8'b0000_0000, t0);
      @(negedge clk); sh_in = 4'b0100;
      @(negedge clk); sh_in = '0;
      repeat (FL + 2) @(negedge clk);
      chk(t_sh[0] == 1'b1, "R8 early shared pulse held", int'(t_sh[0]), 1);
      chk(t_dt[0] == 1'b1, "R8 other dirty seen", int'(t_dt[0]), 1);
      dt_in = '0;
    end

    chk(snp_err == 0, "R7 snoop broadcast", snp_err, 0);
    chk(g_err == 0, "R1 single grant", g_err, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule